// File: doc/BRIEF.md
# Processor State Image Loader

This block restores the full visible and hidden state of a processor core in one privileged operation. After a start strobe it walks a fixed window of physical memory one 16-bit word at a time, from 800h to 864h. Each returned word goes into the register it belongs to. The targets are the general registers, the segment selectors, the instruction pointer, the machine status word, the flags, and eight segment descriptor caches. Six of those caches are segment caches and two are table registers.

Memory is reached through a plain request/ready pair. The loader holds a request and an address until the memory returns ready with the data in the same cycle. Only then does it move the address on. Some words in the window are read but land nowhere.

The machine status word and the flags are merged under protection masks, so reserved bits survive a load. The protection-enable bit can only be set by a load, never cleared. When the last word is taken, the address register rests on 864h and a one-cycle done pulse follows.

Top module: `stateImageLoader`

## Requirements
- R1: When idle with start high at a clock edge, the loader raises memReq with memAddr = 800h. While a load runs, start has no effect on the address sequence.
- R2: One load makes exactly 51 reads, at 800h, 802h, ... 864h in ascending order. memAddr holds its value in every cycle where memReq is high and memReady is low. It advances by 2 only after a cycle with memReady high.
- R3: Each little-endian word is stored as follows:
  - 806h goes to the MSW (merged under R5).
  - 816h goes to trSel and 818h to the flags (merged under R6).
  - 81Ah goes to ip, 81Ch to ldtSel, 81Eh to dsSel, 820h to ssSel, 822h to csSel and 824h to esSel.
  - 826h + 2i goes to gprFile[i] for i = 0..7 (DI, SI, BP, SP, BX, DX, CX, AX).
- R4: Words at 800h–805h and 808h–815h change no output. No register output changes except in the cycle its word is accepted.
- R5: A load changes only MSW bits 3:0. Bits 15:4 keep their value. Once bit 0 (protection enable) is 1, no load clears it.
- R6: A load changes only flag bits 14:6, 4, 2 and 0 (load mask 7FD5h). Bits 15, 5, 3 and 1 keep their value.
- R7: Cache k (0=ES, 1=CS, 2=SS, 3=DS, 4=GDTR, 5=LDT, 6=IDTR, 7=TSS) occupies the three words at 836h + 6k. The first word is base[15:0]. The second word holds base[23:16] in its low byte and the access byte in its high byte. The third word is the limit.
- R8: For caches 4 and 6 the access byte read from memory is discarded. cacheAcc for those entries stays FFh.
- R9: After the final word is accepted, done is high for exactly one cycle, busy and memReq are low, and memAddr reads 864h.
- R10: Reset gives msw = FFF0h, flags = 0002h, cacheAcc = FFh for every entry, memAddr = 800h, and all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (taken only when idle) |
| memReady | input | 1 | Memory has returned memRdata this cycle |
| memRdata | input | 16 | Read data word |
| memReq | output | 1 | Read request |
| memAddr | output | 24 | Read byte address |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| msw | output | 16 | Machine status word |
| flags | output | 16 | Flags word |
| ip | output | 16 | Instruction pointer |
| trSel | output | 16 | Task register selector |
| ldtSel | output | 16 | Local table selector |
| dsSel | output | 16 | DS selector |
| ssSel | output | 16 | SS selector |
| csSel | output | 16 | CS selector |
| esSel | output | 16 | ES selector |
| gprFile | output | 8x16 | General registers, index order of R3 |
| cacheBase | output | 8x24 | Cache base addresses, index order of R7 |
| cacheAcc | output | 8x8 | Cache access bytes |
| cacheLimit | output | 8x16 | Cache limits |

## Verification
Two events can fall in the same cycle: a fresh start strobe and an accepted read in the middle of a running load. One vector keeps memReady high on every cycle and pulses start exactly as the twenty-first word is taken. The run passes only if the read count stays at 51 and the addresses stay in order. A second pairing is a load word that tries to clear protection enable while the bit is already set. That vector is judged by comparing the resulting msw with a mask model kept in the bench.

// File: rtl/loaderPkg.sv
package loaderPkg;
  localparam int IDX_W      = 6;
  localparam int NUM_GPR    = 8;
  localparam int NUM_CACHE  = 8;
  localparam int IMG_WORDS  = 51;
  localparam int LAST_IDX   = IMG_WORDS - 1;

  // word positions inside the image (byte offset / 2)
  localparam int IDX_MSW    = 3;
  localparam int IDX_TR     = 11;
  localparam int IDX_FLAGS  = 12;
  localparam int IDX_IP     = 13;
  localparam int IDX_LDT    = 14;
  localparam int IDX_DS     = 15;
  localparam int IDX_SS     = 16;
  localparam int IDX_CS     = 17;
  localparam int IDX_ES     = 18;
  localparam int GPR_FIRST  = 19;
  localparam int CACHE_FIRST = GPR_FIRST + NUM_GPR;

  localparam logic [15:0] MSW_LOAD_MASK   = 16'h000F;
  localparam logic [15:0] FLAGS_LOAD_MASK = 16'h7FD5;
  localparam logic [15:0] MSW_RESET       = 16'hFFF0;
  localparam logic [15:0] FLAGS_RESET     = 16'h0002;
  // caches that keep a loadable access byte (table registers 4 and 6 do not)
  localparam logic [NUM_CACHE-1:0] ACC_KEPT = 8'b1010_1111;

  typedef struct packed {
    logic             wordWe;
    logic [IDX_W-1:0] wordIdx;
  } ldStrobe_t;
endpackage

// File: rtl/loaderCtrl.sv
module loaderCtrl
  import loaderPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h000800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              memReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              busy,
  output logic              done,
  output ldStrobe_t         strobe
);
  localparam logic [IDX_W-1:0]  LAST_W    = IDX_W'(LAST_IDX);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(2 * LAST_IDX);

  typedef enum logic {ST_IDLE, ST_READ} ctrlState_t;
  ctrlState_t stateQ;
  logic [ADDR_W-1:0] addrQ;
  logic [IDX_W-1:0]  idxQ;
  logic doneQ, fire, lastWord;

  assign fire     = (stateQ == ST_READ) && memReady;
  assign lastWord = (idxQ == LAST_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      addrQ  <= BASE_ADDR;
      idxQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: if (start) begin
          stateQ <= ST_READ;
          addrQ  <= BASE_ADDR;
          idxQ   <= '0;
        end
        ST_READ: if (memReady) begin
          if (lastWord) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end else begin
            addrQ <= addrQ + ADDR_W'(2);
            idxQ  <= idxQ + IDX_W'(1);
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign memReq         = (stateQ == ST_READ);
  assign busy           = (stateQ == ST_READ);
  assign memAddr        = addrQ;
  assign done           = doneQ;
  assign strobe.wordWe  = fire;
  assign strobe.wordIdx = idxQ;

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !lastWord) |=> (memAddr == $past(memAddr) + ADDR_W'(2)));
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> $stable(memAddr));
  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !memReady) |=> ($stable(idxQ) && busy));
  assert_final_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (memAddr == LAST_ADDR && !busy));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/loaderRegs.sv
module loaderRegs
  import loaderPkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  ldStrobe_t                       strobe,
  input  logic [15:0]                     wData,
  output logic [15:0]                     msw,
  output logic [15:0]                     flags,
  output logic [15:0]                     ip,
  output logic [15:0]                     trSel,
  output logic [15:0]                     ldtSel,
  output logic [15:0]                     dsSel,
  output logic [15:0]                     ssSel,
  output logic [15:0]                     csSel,
  output logic [15:0]                     esSel,
  output logic [NUM_GPR-1:0][15:0]        gprFile,
  output logic [NUM_CACHE-1:0][23:0]      cacheBase,
  output logic [NUM_CACHE-1:0][7:0]       cacheAcc,
  output logic [NUM_CACHE-1:0][15:0]      cacheLimit
);
  logic [2:0] cacheHit [NUM_CACHE];

  genvar k, j;
  generate
    for (k = 0; k < NUM_CACHE; k++) begin : g_cache
      for (j = 0; j < 3; j++) begin : g_part
        assign cacheHit[k][j] = strobe.wordWe &&
          (strobe.wordIdx == IDX_W'(CACHE_FIRST + 3 * k + j));
      end
    end
  endgenerate

  // scalar registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msw    <= MSW_RESET;
      flags  <= FLAGS_RESET;
      ip     <= '0;
      trSel  <= '0;
      ldtSel <= '0;
      dsSel  <= '0;
      ssSel  <= '0;
      csSel  <= '0;
      esSel  <= '0;
    end else if (strobe.wordWe) begin
      case (int'(strobe.wordIdx))
        IDX_MSW:   msw <= (msw & ~MSW_LOAD_MASK) | (wData & MSW_LOAD_MASK)
                          | {15'b0, msw[0]};
        IDX_FLAGS: flags <= (flags & ~FLAGS_LOAD_MASK) | (wData & FLAGS_LOAD_MASK);
        IDX_TR:    trSel  <= wData;
        IDX_IP:    ip     <= wData;
        IDX_LDT:   ldtSel <= wData;
        IDX_DS:    dsSel  <= wData;
        IDX_SS:    ssSel  <= wData;
        IDX_CS:    csSel  <= wData;
        IDX_ES:    esSel  <= wData;
        default: ;
      endcase
    end
  end

  // general registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gprFile <= '0;
    end else begin
      for (int g = 0; g < NUM_GPR; g++)
        if (strobe.wordWe && strobe.wordIdx == IDX_W'(GPR_FIRST + g))
          gprFile[g] <= wData;
    end
  end

  // descriptor caches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheBase  <= '0;
      cacheAcc   <= '1;
      cacheLimit <= '0;
    end else begin
      for (int c = 0; c < NUM_CACHE; c++) begin
        if (cacheHit[c][0]) cacheBase[c][15:0]  <= wData;
        if (cacheHit[c][1]) begin
          cacheBase[c][23:16] <= wData[7:0];
          if (ACC_KEPT[c]) cacheAcc[c] <= wData[15:8];
        end
        if (cacheHit[c][2]) cacheLimit[c] <= wData;
      end
    end
  end

  assert_pe_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    msw[0] |=> msw[0]);
  assert_msw_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordWe |=> $stable(msw[15:4]));
  assert_flags_reserved_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordWe |=> $stable(flags & ~FLAGS_LOAD_MASK));
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wordWe |=> ($stable(gprFile) && $stable(msw) && $stable(cacheBase)));
  assert_table_acc_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordWe |=> (cacheAcc[4] == $past(cacheAcc[4]) && cacheAcc[6] == $past(cacheAcc[6])));
endmodule

// File: rtl/stateImageLoader.sv
module stateImageLoader
  import loaderPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h000800
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       memReady,
  input  logic [15:0]                memRdata,
  output logic                       memReq,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       busy,
  output logic                       done,
  output logic [15:0]                msw,
  output logic [15:0]                flags,
  output logic [15:0]                ip,
  output logic [15:0]                trSel,
  output logic [15:0]                ldtSel,
  output logic [15:0]                dsSel,
  output logic [15:0]                ssSel,
  output logic [15:0]                csSel,
  output logic [15:0]                esSel,
  output logic [NUM_GPR-1:0][15:0]   gprFile,
  output logic [NUM_CACHE-1:0][23:0] cacheBase,
  output logic [NUM_CACHE-1:0][7:0]  cacheAcc,
  output logic [NUM_CACHE-1:0][15:0] cacheLimit
);
  ldStrobe_t strobe;

  loaderCtrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memReady(memReady),
    .memReq(memReq), .memAddr(memAddr), .busy(busy), .done(done),
    .strobe(strobe)
  );

  loaderRegs u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wData(memRdata),
    .msw(msw), .flags(flags), .ip(ip), .trSel(trSel), .ldtSel(ldtSel),
    .dsSel(dsSel), .ssSel(ssSel), .csSel(csSel), .esSel(esSel),
    .gprFile(gprFile), .cacheBase(cacheBase), .cacheAcc(cacheAcc),
    .cacheLimit(cacheLimit)
  );
endmodule

// File: tb/stateImageLoader_bench.sv
`timescale 1ns/1ps
module stateImageLoader_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic memReady = 1'b0;
  logic [15:0] memRdata;
  logic memReq, busy, done;
  logic [23:0] memAddr;
  logic [15:0] msw, flags, ip, trSel, ldtSel, dsSel, ssSel, csSel, esSel;
  logic [7:0][15:0] gprFile;
  logic [7:0][23:0] cacheBase;
  logic [7:0][7:0]  cacheAcc;
  logic [7:0][15:0] cacheLimit;

  always #2 clk = ~clk;

  stateImageLoader u_stateImageLoader (
    .clk(clk), .rstN(rstN), .start(start), .memReady(memReady),
    .memRdata(memRdata), .memReq(memReq), .memAddr(memAddr), .busy(busy),
    .done(done), .msw(msw), .flags(flags), .ip(ip), .trSel(trSel),
    .ldtSel(ldtSel), .dsSel(dsSel), .ssSel(ssSel), .csSel(csSel),
    .esSel(esSel), .gprFile(gprFile), .cacheBase(cacheBase),
    .cacheAcc(cacheAcc), .cacheLimit(cacheLimit)
  );

  typedef struct packed {
    logic [15:0] seed;
    logic [15:0] mswV;
    logic [15:0] flV;
    logic [1:0]  waitN;
    logic        midStart;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{16'h1111, 16'h000E, 16'hFFFF, 2'd0, 1'b1},
    '{16'h2222, 16'h0001, 16'h0000, 2'd1, 1'b0},
    '{16'h3333, 16'h0000, 16'hA5A5, 2'd2, 1'b1},
    '{16'h4444, 16'hFFF6, 16'h5A5A, 2'd3, 1'b0}
  };

  logic [15:0] curSeed = 16'h0, curMsw = 16'h0, curFl = 16'h0;
  int checkCnt = 0, failCnt = 0;
  logic [15:0] mswExp = 16'hFFF0, flagsExp = 16'h0002;

  function automatic logic [15:0] img(input logic [23:0] a, input logic [15:0] sd,
                                      input logic [15:0] mv, input logic [15:0] fv);
    logic [15:0] t;
    t = a[15:0] * 16'h9E37;
    if (a == 24'h806) return mv;
    if (a == 24'h818) return fv;
    return t ^ sd;
  endfunction

  assign memRdata = img(memAddr, curSeed, curMsw, curFl);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  task automatic runLoad(input int v);
    int reads = 0, orderBad = 0, cyc = 0, guard = 0;
    logic rdy;
    logic [15:0] prevMsw, prevFl;
    logic [15:0] w1;
    curSeed = VECS[v].seed; curMsw = VECS[v].mswV; curFl = VECS[v].flV;
    prevMsw = msw; prevFl = flags;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && guard < 2000) begin
      rdy = (VECS[v].waitN == 0) || (cyc % (int'(VECS[v].waitN) + 1) == 0);
      cyc++;
      memReady = rdy;
      start = (VECS[v].midStart && reads == 20);
      if (memReq && rdy) begin
        if (memAddr != 24'h800 + 24'(2 * reads)) orderBad++;
        if (memAddr == 24'h806) begin
          chk("R4 msw before skipped words pass", {48'b0, msw}, {48'b0, prevMsw});
          chk("R4 flags untouched early", {48'b0, flags}, {48'b0, prevFl});
        end
        reads++;
      end
      @(negedge clk); guard++;
    end
    memReady = 1'b0; start = 1'b0;
    chk("R2 read count (R1 start ignored)", 64'(reads), 64'd51);
    chk("R2 address order", 64'(orderBad), 64'd0);
    chk("R9 done seen", {63'b0, done}, 64'd1);
    chk("R9 final address", {40'b0, memAddr}, 64'h864);
    chk("R9 busy low", {62'b0, busy, memReq}, 64'd0);
    mswExp   = (mswExp & ~16'h000F) | (VECS[v].mswV & 16'h000F) | {15'b0, mswExp[0]};
    flagsExp = (flagsExp & ~16'h7FD5) | (VECS[v].flV & 16'h7FD5);
    chk("R5 msw merge", {48'b0, msw}, {48'b0, mswExp});
    chk("R6 flags merge", {48'b0, flags}, {48'b0, flagsExp});
    chk("R3 tr/ip/ldt", {16'b0, trSel, ip, ldtSel},
        {16'b0, img(24'h816, curSeed, curMsw, curFl), img(24'h81A, curSeed, curMsw, curFl),
         img(24'h81C, curSeed, curMsw, curFl)});
    chk("R3 ds/ss/cs/es", {dsSel, ssSel, csSel, esSel},
        {img(24'h81E, curSeed, curMsw, curFl), img(24'h820, curSeed, curMsw, curFl),
         img(24'h822, curSeed, curMsw, curFl), img(24'h824, curSeed, curMsw, curFl)});
    for (int i = 0; i < 8; i++)
      chk($sformatf("R3 gpr %0d", i), {48'b0, gprFile[i]},
          {48'b0, img(24'h826 + 24'(2 * i), curSeed, curMsw, curFl)});
    for (int k = 0; k < 8; k++) begin
      w1 = img(24'h838 + 24'(6 * k), curSeed, curMsw, curFl);
      chk($sformatf("R7 cache %0d base", k), {40'b0, cacheBase[k]},
          {40'b0, w1[7:0], img(24'h836 + 24'(6 * k), curSeed, curMsw, curFl)});
      chk($sformatf("R7 cache %0d limit", k), {48'b0, cacheLimit[k]},
          {48'b0, img(24'h83A + 24'(6 * k), curSeed, curMsw, curFl)});
      chk($sformatf("R8 R7 cache %0d access", k), {56'b0, cacheAcc[k]},
          {56'b0, (k == 4 || k == 6) ? 8'hFF : w1[15:8]});
    end
    @(negedge clk);
    chk("R9 done one cycle", {63'b0, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    checkCnt++; failCnt++;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R10 msw reset", {48'b0, msw}, 64'hFFF0);
    chk("R10 flags reset", {48'b0, flags}, 64'h0002);
    chk("R10 access reset", {cacheAcc}, {8{8'hFF}});
    chk("R10 gpr reset", {gprFile[3:0]}, 64'd0);
    chk("R10 addr reset", {40'b0, memAddr}, 64'h800);
    chk("R1 idle no request", {61'b0, memReq, busy, done}, 64'd0);
    // stimulus table
    for (int v = 0; v < 4; v++) runLoad(v);
    // directed: protection enable stays set (R5), reset restores
    chk("R5 protection enable held", {63'b0, msw[0]}, 64'd1);
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 msw after second reset", {48'b0, msw}, 64'hFFF0);
    chk("R10 caches cleared", {40'b0, cacheBase[1]}, 64'd0);
    mswExp = 16'hFFF0; flagsExp = 16'h0002;
    runLoad(2);
    summary();
    $finish;
  end
endmodule